// File: doc/BRIEF.md
# ADC Result Buffer and Status Registers

This block is the register face of a multi-channel analog-to-digital conversion engine. A conversion sequencer hands it one result at a time, tagged with a channel index. When a whole measurement cycle is finished, the sequencer raises a one-cycle done pulse. The block holds each strobed result in a per-channel staging register. On the done pulse it moves every staged result into that channel's readable data buffer, sets the channel's valid flag and raises a global end-of-cycle event.

Software reaches the block over a byte-wide peripheral bus with fixed offsets. Reading a channel's data buffer consumes the result and drops that channel's valid flag. The end-of-cycle event stays up until every valid flag has been consumed. A new result that lands on a result software never read replaces the old data, keeps the valid flag set and latches a sticky overflow event, which software clears by writing a one.

There are two synchronous resets. Power-up reset clears everything. Warm reset clears everything except a single software-owned status bit.

Top module: `adc_result_regs`

## Requirements
- R1: Register offsets are as follows: status at 0; control of channel i at 6+2i; data buffer of channel i at 7+2i. Reads of offsets 1 to 5 and of any offset past the last channel return 0. Writes to data buffers and to unmapped offsets have no effect.
- R2: `bus_rdata` is registered. It takes the addressed value at the clock edge where `bus_rd` is high and holds that value while `bus_rd` is low.
- R3: A result strobe for an enabled channel is staged. It reaches the data buffer, and sets valid (control bit 7), only on a `cycle_done` pulse, including a pulse in the same cycle as the strobe. Strobes for disabled channels are ignored.
- R4: A bus read of a channel's data buffer offset clears that channel's valid bit.
- R5: Status bit 0 (end of cycle) sets at the edge of a `cycle_done` pulse that commits at least one result. It stays set while any valid bit is set, and clears one clock after the last valid bit clears.
- R6: When a commit hits a channel whose valid bit is still set, the buffer takes the new data, valid stays set and status bit 1 (overflow) sets.
- R7: Writing 1 to status bit 1 clears it and writing 0 leaves it unchanged. If a hardware set and a software clear fall in the same cycle, the set wins.
- R8: Status bits 7 to 3 read 0. Status bit 2 is a software read/write bit.
- R9: Power-up reset (`rst`) clears all registers, including status bit 2 and `bus_rdata`.
- R10: Warm reset (`warm_rst`) clears valid, enable, buffer, staging, overflow and end-of-cycle state, and leaves status bit 2 unchanged.
- R11: Control bit 0 is a read/write enable. Control bits 6 to 1 read 0, and bit 7 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| res_stb | input | 1 | Result strobe from the sequencer |
| res_chan | input | CH_W | Channel index of the strobed result |
| res_data | input | DATA_W | Result word |
| cycle_done | input | 1 | One-cycle pulse marking the end of a measurement cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench goes after the races at the edges of the status bits.

The first is a result strobe, a done pulse and a write-1 clear of overflow all in one cycle. A design that lets the clear win loses the overflow. A design that ignores a same-cycle strobe commits stale staging data.

The bench also checks that end-of-cycle stays up while one channel remains unread and falls once the last one is read. A design that clears it on the first read, or never clears it, shows up in the status reads.

Finally, it separates warm reset from power-up reset. A design that clears the preserved bit on warm reset, or that keeps buffer or enable state through it, gives a wrong status or control read.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  localparam int STAT_OFS  = 0;
  localparam int CHAN_BASE = 6;
  localparam int BUS_W     = 8;

  localparam int EOC_BIT  = 0;
  localparam int OVF_BIT  = 1;
  localparam int KEEP_BIT = 2;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_VAL_BIT = 7;

  function automatic int ctl_ofs(input int ch);
    return CHAN_BASE + 2 * ch;
  endfunction

  function automatic int dat_ofs(input int ch);
    return CHAN_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/adc_rb_decode.sv
module adc_rb_decode
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic [NUM_CH-1:0] ctl_wr,
  output logic [NUM_CH-1:0] ctl_rd,
  output logic [NUM_CH-1:0] dat_rd
);
  assign stat_wr = wr && (addr == ADDR_W'(STAT_OFS));
  assign stat_rd = rd && (addr == ADDR_W'(STAT_OFS));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ctl_wr[i] = wr && (addr == ADDR_W'(ctl_ofs(i)));
    assign ctl_rd[i] = rd && (addr == ADDR_W'(ctl_ofs(i)));
    assign dat_rd[i] = rd && (addr == ADDR_W'(dat_ofs(i)));
  end
endmodule

// File: rtl/adc_rb_slot.sv
module adc_rb_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ctl_wr,
  input  logic              en_wdata,
  input  logic              stb,
  input  logic [DATA_W-1:0] stb_data,
  input  logic              commit,
  input  logic              dat_rd,
  output logic              en_q,
  output logic              valid_q,
  output logic [DATA_W-1:0] dbuf_q,
  output logic              took,
  output logic              ovf_hit
);
  logic [DATA_W-1:0] stage_q;
  logic              pend_q;
  logic              stb_ok;
  logic              pend_eff;
  logic [DATA_W-1:0] stage_eff;

  // a strobe in the commit cycle belongs to the closing cycle
  assign stb_ok    = stb && en_q;
  assign pend_eff  = pend_q || stb_ok;
  assign stage_eff = stb_ok ? stb_data : stage_q;
  assign took      = commit && pend_eff;
  // an old result read in the commit cycle is not lost
  assign ovf_hit   = took && valid_q && !dat_rd;

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      dbuf_q  <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= en_wdata;
      if (took) begin
        dbuf_q  <= stage_eff;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end else begin
        if (stb_ok) begin
          stage_q <= stb_data;
          pend_q  <= 1'b1;
        end
        if (dat_rd) valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_rb_status.sv
module adc_rb_status
  import adc_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             warm_rst,
  input  logic             took_any,
  input  logic             ovf_any,
  input  logic             any_valid,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic             eoc_q,
  output logic             ovf_q,
  output logic             keep_q
);
  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      eoc_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (took_any)       eoc_q <= 1'b1;
      else if (!any_valid) eoc_q <= 1'b0;
      if (ovf_any)                  ovf_q <= 1'b1;
      else if (wr && wdata[OVF_BIT]) ovf_q <= 1'b0;
    end
  end

  // preserved across warm reset
  always_ff @(posedge clk) begin
    if (rst)     keep_q <= 1'b0;
    else if (wr) keep_q <= wdata[KEEP_BIT];
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              res_stb,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic              cycle_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic              stat_wr, stat_rd;
  logic [NUM_CH-1:0] ctl_wr, ctl_rd, dat_rd;
  logic [NUM_CH-1:0] en_vec, valid_vec, took_vec, ovf_vec;
  logic [DATA_W-1:0] dbuf_arr [NUM_CH];
  logic              took_any, ovf_any;
  logic              stat_eoc, stat_ovf, stat_keep;
  logic              slot_clr;
  logic [BUS_W-1:0]  rd_next;

  assign slot_clr = rst || warm_rst;

  adc_rb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .stat_wr(stat_wr), .stat_rd(stat_rd),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .dat_rd(dat_rd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic stb_i;
    assign stb_i = res_stb && (res_chan == CH_W'(i));
    adc_rb_slot #(.DATA_W(DATA_W)) slot_i (
      .clk(clk), .clr(slot_clr),
      .ctl_wr(ctl_wr[i]), .en_wdata(bus_wdata[CTL_EN_BIT]),
      .stb(stb_i), .stb_data(res_data),
      .commit(cycle_done), .dat_rd(dat_rd[i]),
      .en_q(en_vec[i]), .valid_q(valid_vec[i]), .dbuf_q(dbuf_arr[i]),
      .took(took_vec[i]), .ovf_hit(ovf_vec[i])
    );
  end

  assign took_any = |took_vec;
  assign ovf_any  = |ovf_vec;

  adc_rb_status stat_i (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .took_any(took_any), .ovf_any(ovf_any), .any_valid(|valid_vec),
    .wr(stat_wr), .wdata(bus_wdata),
    .eoc_q(stat_eoc), .ovf_q(stat_ovf), .keep_q(stat_keep)
  );

  always_comb begin
    rd_next = '0;
    if (stat_rd) begin
      rd_next[EOC_BIT]  = stat_eoc;
      rd_next[OVF_BIT]  = stat_ovf;
      rd_next[KEEP_BIT] = stat_keep;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctl_rd[i]) begin
        rd_next[CTL_EN_BIT]  = en_vec[i];
        rd_next[CTL_VAL_BIT] = valid_vec[i];
      end
      if (dat_rd[i]) rd_next = BUS_W'(dbuf_arr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (slot_clr)    bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              warm_rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [NUM_CH-1:0] valid_vec,
  input logic              stat_eoc,
  input logic              stat_ovf,
  input logic              took_any,
  input logic              ovf_any
);
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (bus_rd && bus_addr >= ADDR_W'(1) && bus_addr <= ADDR_W'(5)) |=> (bus_rdata == 8'h00));

  // R5
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    took_any |=> stat_eoc);

  // R5
  eoc_drop_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (stat_eoc && valid_vec == '0 && !took_any) |=> !stat_eoc);

  // R6
  ovf_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    ovf_any |=> (valid_vec != '0));

  // R7
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    ovf_any |=> stat_ovf);

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (bus_rd && bus_addr == '0) |=> (bus_rdata[7:3] == 5'd0));

  // R10
  warm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> (!stat_eoc && !stat_ovf && valid_vec == '0));

  // R9
  por_clear_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == 8'h00 && !stat_eoc && !stat_ovf && valid_vec == '0));
endmodule

bind adc_result_regs adc_result_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/adc_result_regs_tb_top.sv
`timescale 1ns/1ps
module adc_result_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       warm_rst = 1'b0;
  logic       res_stb = 1'b0;
  logic [1:0] res_chan = '0;
  logic [7:0] res_data = '0;
  logic       cycle_done = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_result_regs dut_i (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .res_stb(res_stb), .res_chan(res_chan), .res_data(res_data),
    .cycle_done(cycle_done),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [4:0] ctl_a(input int ch); return 5'(6 + 2 * ch); endfunction
  function automatic logic [4:0] dat_a(input int ch); return 5'(7 + 2 * ch); endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req, input string what);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, what, bus_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic strobe(input int ch, input logic [7:0] d);
    @(negedge clk);
    res_chan = 2'(ch); res_data = d; res_stb = 1'b1;
    @(negedge clk);
    res_stb = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(5'd0, 8'h00, "R9", "status after power-up");
    rd_chk(ctl_a(0), 8'h00, "R9", "ctl0 after power-up");
    rd_chk(dat_a(0), 8'h00, "R9", "data0 after power-up");
  endtask

  task automatic t_map();
    wr(ctl_a(0), 8'hFF);
    rd_chk(ctl_a(0), 8'h01, "R11", "ctl0 enable only");
    repeat (3) @(negedge clk);
    check("R2", "rdata held", bus_rdata, 8'h01);
    wr(ctl_a(2), 8'h01);
    wr(dat_a(0), 8'hAB);
    rd_chk(dat_a(0), 8'h00, "R1", "data write ignored");
    rd_chk(5'd3, 8'h00, "R1", "offset 3 reads 0");
    rd_chk(5'd14, 8'h00, "R1", "offset past channels reads 0");
  endtask

  task automatic t_capture();
    strobe(0, 8'h5A);
    strobe(1, 8'h33);
    strobe(2, 8'hC3);
    rd_chk(ctl_a(0), 8'h01, "R3", "no valid before done");
    rd_chk(5'd0, 8'h00, "R5", "no eoc before done");
    done_pulse();
    rd_chk(5'd0, 8'h01, "R5", "eoc after done");
    rd_chk(ctl_a(0), 8'h81, "R3", "ctl0 valid");
    rd_chk(ctl_a(1), 8'h00, "R3", "disabled ch1 not valid");
    rd_chk(ctl_a(2), 8'h81, "R3", "ctl2 valid");
    rd_chk(dat_a(1), 8'h00, "R3", "disabled ch1 data");
    rd_chk(dat_a(0), 8'h5A, "R3", "data0");
    rd_chk(ctl_a(0), 8'h01, "R4", "valid0 cleared by read");
    rd_chk(5'd0, 8'h01, "R5", "eoc held while ch2 valid");
    rd_chk(dat_a(2), 8'hC3, "R3", "data2");
    rd_chk(5'd0, 8'h00, "R5", "eoc dropped after last read");
  endtask

  task automatic t_overflow();
    strobe(0, 8'h11); done_pulse();
    strobe(0, 8'h22); done_pulse();
    rd_chk(5'd0, 8'h03, "R6", "overflow set");
    rd_chk(ctl_a(0), 8'h81, "R6", "valid kept");
    wr(5'd0, 8'h00);
    rd_chk(5'd0, 8'h03, "R7", "write 0 no effect");
    wr(5'd0, 8'h02);
    rd_chk(5'd0, 8'h01, "R7", "write 1 clears");
    rd_chk(dat_a(0), 8'h22, "R6", "new data kept");
    rd_chk(5'd0, 8'h00, "R5", "eoc dropped");
  endtask

  task automatic t_set_wins();
    strobe(0, 8'h30); done_pulse();
    @(negedge clk);
    res_chan = 2'd0; res_data = 8'h44; res_stb = 1'b1; cycle_done = 1'b1;
    bus_addr = 5'd0; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk);
    res_stb = 1'b0; cycle_done = 1'b0; bus_wr = 1'b0;
    rd_chk(5'd0, 8'h03, "R7", "hw set beats clear");
    rd_chk(dat_a(0), 8'h44, "R3", "same-cycle strobe committed");
    wr(5'd0, 8'h02);
    rd_chk(5'd0, 8'h00, "R7", "status clean");
  endtask

  task automatic t_resets();
    wr(5'd0, 8'hFC);
    rd_chk(5'd0, 8'h04, "R8", "reserved 0, bit2 set");
    strobe(0, 8'h55); done_pulse();
    strobe(0, 8'h66); done_pulse();
    rd_chk(5'd0, 8'h07, "R8", "bit2 with eoc and ovf");
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    rd_chk(5'd0, 8'h04, "R10", "warm keeps bit2 only");
    rd_chk(ctl_a(0), 8'h00, "R10", "ctl0 cleared");
    rd_chk(ctl_a(2), 8'h00, "R10", "ctl2 cleared");
    rd_chk(dat_a(0), 8'h00, "R10", "data0 cleared");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk(5'd0, 8'h00, "R9", "power-up clears bit2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_capture();
    t_overflow();
    t_set_wins();
    t_resets();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule